// File: doc/BRIEF.md
# Programmable 16/32-bit CRC Engine

This block computes a cyclic redundancy checksum over a byte stream under software control, through a small byte-wide register bus. Software picks the generator width (16 or 32 bits) and writes the generator polynomial. It then sets a mode bit so that data-register writes load the seed, writes the seed, and clears the mode bit. After that, each write of one raw byte to the lowest data register folds that byte into the running checksum.

The checksum is read back from the data registers at any time. A control bit can present the checksum bitwise inverted on the read path only. The stored state is never altered by reading it or by setting that bit, so a mid-stream read does not disturb the calculation. The update is most-significant-bit first, non-reflected, and shifts left through the stored polynomial. One byte is absorbed per clock, so bytes may be written on consecutive cycles.

Top module: `crc_engine`

## Requirements
- R1: After a synchronous reset, the control register reads 0x00, the polynomial registers read 0x00,0x00,0x10,0x21 at addresses 4..7, and all four data registers read 0xFF.
- R2: Address 8 is the control register. Bit 0 selects the width (0 = 16-bit, 1 = 32-bit), bit 1 selects seed mode, and bit 2 selects inverted read-back. Bits 2:0 read back as written, and bits 7:3 (bit 3 being a reserved bit) always read 0.
- R3: In seed mode (control bit 1 = 1), a write to data address k (0..3) replaces byte k of the checksum state and does not advance the CRC. Address 0 holds bits 31:24 and address 3 holds bits 7:0.
- R4: With seed mode clear, a write to data address 3 advances the CRC by one byte, MSB-first, using the stored polynomial. The result is readable on the next cycle, and the next byte may be written on that same next cycle.
- R5: With seed mode clear, writes to data addresses 0, 1 and 2 leave the checksum state unchanged.
- R6: In 16-bit mode the CRC uses only polynomial addresses 6:7 and state addresses 2:3. Data addresses 0 and 1 read 0x00, and the upper state bytes are not changed by byte updates.
- R7: In 32-bit mode the CRC uses all four polynomial bytes (address 4 most significant) and all four state bytes.
- R8: When control bit 2 is 1, data-register reads return the bitwise inverse of the state. Setting or clearing that bit never changes the stored state.
- R9: Polynomial addresses 4..7 read back the byte last written. Addresses 9..15 read 0x00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address for both read and write |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Combinational read data for bus_addr |

## Verification
On every cycle, the assertions check several things. The state holds when neither a seed load nor a byte step occurs. A seed write lands in the addressed lane, and a 16-bit step leaves the upper state half alone. The control reserved bits and the narrow-mode upper data bytes read zero, and inverted read-back mirrors the state. Whether each byte step produces the correct remainder can only be shown by the bench scenarios. These cover full sweeps over every byte value in both widths, known-answer strings, back-to-back byte writes and mid-stream width or inversion changes, all checked against an arithmetic model.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;
    localparam int BYTE_W    = 8;
    localparam int NUM_LANES = 4;
    localparam int STATE_W   = BYTE_W * NUM_LANES;
    localparam int NARROW_W  = 16;
    localparam int ADDR_W    = 4;

    localparam logic [ADDR_W-1:0] ADDR_DATA0 = 4'd0;
    localparam logic [ADDR_W-1:0] ADDR_POLY0 = 4'd4;
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 4'd8;

    localparam logic [STATE_W-1:0] POLY_RST  = 32'h0000_1021;
    localparam logic [STATE_W-1:0] STATE_RST = '1;

    typedef struct packed {
        logic inv_read;
        logic seed_mode;
        logic wide;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Low bit index of lane i (lane 0 is the most significant byte)
    function automatic int lane_lo(input int i);
        return BYTE_W * (NUM_LANES - 1 - i);
    endfunction

    // One byte of MSB-first, non-reflected CRC
    function automatic logic [STATE_W-1:0] step_byte(
        input logic [STATE_W-1:0] cur,
        input logic [STATE_W-1:0] poly,
        input logic [BYTE_W-1:0]  din,
        input logic               wide
    );
        logic [STATE_W-1:0]  acc;
        logic [NARROW_W-1:0] nar;
        acc = cur ^ {din, {(STATE_W-BYTE_W){1'b0}}};
        nar = cur[NARROW_W-1:0] ^ {din, {(NARROW_W-BYTE_W){1'b0}}};
        for (int k = 0; k < BYTE_W; k++) begin
            acc = acc[STATE_W-1]  ? ((acc << 1) ^ poly) : (acc << 1);
            nar = nar[NARROW_W-1] ? ((nar << 1) ^ poly[NARROW_W-1:0]) : (nar << 1);
        end
        return wide ? acc : {cur[STATE_W-1:NARROW_W], nar};
    endfunction
endpackage

// File: rtl/crc_cfg_regs.sv
module crc_cfg_regs
    import crc_eng_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BYTE_W-1:0]   wdata,
    output ctrl_t               ctrl,
    output logic [STATE_W-1:0]  poly
);
    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (wr_en && addr == ADDR_CTRL)
            ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
    end

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_poly
        localparam int LO = lane_lo(i);
        always_ff @(posedge clk) begin
            if (rst)
                poly[LO +: BYTE_W] <= POLY_RST[LO +: BYTE_W];
            else if (wr_en && addr == ADDR_POLY0 + ADDR_W'(i))
                poly[LO +: BYTE_W] <= wdata;
        end
    end

    assign ctrl = ctrl_q;

    a_r1_ctrl_reset: assert property (@(posedge clk) rst |=> (ctrl == '0));
    a_r9_poly_low_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_POLY0 + 4'd3) |=> (poly[BYTE_W-1:0] == $past(wdata)));
endmodule

// File: rtl/crc_state.sv
module crc_state
    import crc_eng_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_LANES-1:0]  lane_we,
    input  logic [BYTE_W-1:0]     wdata,
    input  ctrl_t                 ctrl,
    input  logic [STATE_W-1:0]    poly,
    output logic [STATE_W-1:0]    state
);
    logic advance;
    logic seed_any;

    assign advance  = lane_we[NUM_LANES-1] && !ctrl.seed_mode;
    assign seed_any = (|lane_we) && ctrl.seed_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= STATE_RST;
        end else if (advance) begin
            state <= step_byte(state, poly, wdata, ctrl.wide);
        end else if (ctrl.seed_mode) begin
            for (int i = 0; i < NUM_LANES; i++)
                if (lane_we[i])
                    state[lane_lo(i) +: BYTE_W] <= wdata;
        end
    end

    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!advance && !seed_any) |=> $stable(state));
    a_r3_seed_low_lane: assert property (@(posedge clk) disable iff (rst)
        (lane_we[NUM_LANES-1] && ctrl.seed_mode) |=> (state[BYTE_W-1:0] == $past(wdata)));
    a_r6_narrow_upper: assert property (@(posedge clk) disable iff (rst)
        (advance && !ctrl.wide) |=> (state[STATE_W-1:NARROW_W] == $past(state[STATE_W-1:NARROW_W])));
endmodule

// File: rtl/crc_read_mux.sv
module crc_read_mux
    import crc_eng_pkg::*;
(
    input  logic [ADDR_W-1:0]   addr,
    input  ctrl_t               ctrl,
    input  logic [STATE_W-1:0]  poly,
    input  logic [STATE_W-1:0]  state,
    output logic [BYTE_W-1:0]   rdata
);
    logic [STATE_W-1:0] view;
    logic [BYTE_W-1:0]  data_lane [NUM_LANES];
    logic [BYTE_W-1:0]  poly_lane [NUM_LANES];

    assign view = ctrl.inv_read ? ~state : state;

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        localparam int LO = lane_lo(i);
        if (i < NUM_LANES - NARROW_W / BYTE_W) begin : g_upper
            assign data_lane[i] = ctrl.wide ? view[LO +: BYTE_W] : '0;
        end else begin : g_lower
            assign data_lane[i] = view[LO +: BYTE_W];
        end
        assign poly_lane[i] = poly[LO +: BYTE_W];
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (addr == ADDR_DATA0 + ADDR_W'(i)) rdata = data_lane[i];
            if (addr == ADDR_POLY0 + ADDR_W'(i)) rdata = poly_lane[i];
        end
        if (addr == ADDR_CTRL)
            rdata = {{(BYTE_W-CTRL_W){1'b0}}, ctrl};
    end
endmodule

// File: rtl/crc_engine.sv
module crc_engine
    import crc_eng_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [BYTE_W-1:0]   bus_rdata
);
    ctrl_t                 ctrl;
    logic [STATE_W-1:0]    poly;
    logic [STATE_W-1:0]    state;
    logic [NUM_LANES-1:0]  lane_we;

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_dec
        assign lane_we[i] = bus_wr && (bus_addr == ADDR_DATA0 + ADDR_W'(i));
    end

    crc_cfg_regs u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .ctrl  (ctrl),
        .poly  (poly)
    );

    crc_state u_state (
        .clk     (clk),
        .rst     (rst),
        .lane_we (lane_we),
        .wdata   (bus_wdata),
        .ctrl    (ctrl),
        .poly    (poly),
        .state   (state)
    );

    crc_read_mux u_rd (
        .addr  (bus_addr),
        .ctrl  (ctrl),
        .poly  (poly),
        .state (state),
        .rdata (bus_rdata)
    );

    a_r2_ctrl_reserved: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_CTRL) |-> (bus_rdata[BYTE_W-1:CTRL_W] == '0));
    a_r6_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.wide && bus_addr < 4'd2) |-> (bus_rdata == '0));
    a_r8_inv_read: assert property (@(posedge clk) disable iff (rst)
        (ctrl.inv_read && bus_addr == 4'd3) |-> (bus_rdata == ~state[BYTE_W-1:0]));
endmodule

// File: tb/crc_engine_tb_top.sv
module crc_engine_tb_top;
    logic       clk = 0;
    logic       rst = 1;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2 clk = ~clk;  // 250 MHz

    crc_engine dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] model(input logic [31:0] crc, input logic [31:0] poly,
                                          input logic [7:0] b, input bit wide);
        logic [31:0] c = crc;
        int msb = wide ? 31 : 15;
        for (int k = 7; k >= 0; k--) begin
            bit fb = c[msb] ^ b[k];
            c = c << 1;
            if (fb) c = c ^ poly;
        end
        if (!wide) c = {crc[31:16], c[15:0]};
        return c;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd32(input logic [3:0] base, output logic [31:0] v);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin
            rd(base + 4'(i), b);
            v[8*(3-i) +: 8] = b;
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic seed(input logic [31:0] s, input logic [7:0] ctrl_after);
        wr(8, ctrl_after | 8'h02);
        for (int i = 0; i < 4; i++) wr(4'(i), s[8*(3-i) +: 8]);
        wr(8, ctrl_after);
    endtask

    task automatic set_poly(input logic [31:0] p);
        for (int i = 0; i < 4; i++) wr(4'(4 + i), p[8*(3-i) +: 8]);
    endtask

    initial begin
        logic [31:0] v, exp;
        logic [7:0]  b;
        string s = "123456789";
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        rd(8, b); check("R1 ctrl", {24'h0, b}, 32'h0);
        rd32(4, v); check("R1 poly", v, 32'h0000_1021);
        wr(8, 8'h01); rd32(0, v); check("R1 data", v, 32'hFFFF_FFFF);

        // R2 control readback
        wr(8, 8'hFF); rd(8, b); check("R2 ctrl masked", {24'h0, b}, 32'h07);
        wr(8, 8'h00); rd(8, b); check("R2 ctrl clear", {24'h0, b}, 32'h0);

        // R9 poly readback and unmapped
        set_poly(32'hA5C3_5A3C); rd32(4, v); check("R9 poly rw", v, 32'hA5C3_5A3C);
        for (int a = 9; a < 16; a++) begin
            wr(4'(a), 8'h5A); rd(4'(a), b); check("R9 unmapped", {24'h0, b}, 32'h0);
        end
        rd32(4, v); check("R9 poly untouched", v, 32'hA5C3_5A3C);

        // R3 seed load, 32-bit view
        seed(32'h1234_5678, 8'h01); rd32(0, v); check("R3 seed", v, 32'h1234_5678);

        // R5 non-low data writes in data mode ignored
        wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'h00);
        rd32(0, v); check("R5 ignored", v, 32'h1234_5678);

        // R4/R6 16-bit known answer, back-to-back bytes
        set_poly(32'h0000_1021); seed(32'hFFFF_FFFF, 8'h00);
        @(negedge clk);
        bus_addr = 3; bus_wr = 1;
        for (int i = 0; i < 9; i++) begin
            bus_wdata = s[i];
            @(negedge clk);
        end
        bus_wr = 0;
        rd32(0, v); check("R4 ccitt 16 b2b", v, 32'h0000_29B1);
        wr(8, 8'h01); rd32(0, v); check("R6 upper untouched", v[31:16], 32'hFFFF);

        // R7 32-bit known answer
        set_poly(32'h04C1_1DB7); seed(32'hFFFF_FFFF, 8'h01);
        for (int i = 0; i < 9; i++) wr(3, s[i]);
        rd32(0, v); check("R7 crc32 kat", v, 32'h0376_E6E7);

        // R8 inverted read; state preserved
        wr(8, 8'h05); rd32(0, v); check("R8 inverted", v, ~32'h0376_E6E7);
        wr(8, 8'h01); rd32(0, v); check("R8 state kept", v, 32'h0376_E6E7);
        wr(8, 8'h05); wr(3, 8'h42); wr(8, 8'h01);
        rd32(0, v); check("R8 step after inv", v, model(32'h0376_E6E7, 32'h04C1_1DB7, 8'h42, 1));

        // R6 sweep all bytes, 16-bit, upper poly bytes junk
        set_poly(32'hDEAD_8005);
        for (int d = 0; d < 256; d++) begin
            seed(32'hFFFF_0000 | (32'(d) * 32'h0101), 8'h00);
            wr(3, 8'(d));
            exp = model(32'hFFFF_0000 | (32'(d) * 32'h0101), 32'h0000_8005, 8'(d), 0);
            rd32(0, v); check("R6 sweep16", v, {16'h0, exp[15:0]});
        end
        wr(8, 8'h04); rd(0, b); check("R6 d0 zero inv", {24'h0, b}, 32'h0);

        // R7 sweep all bytes, 32-bit
        set_poly(32'h04C1_1DB7);
        for (int d = 0; d < 256; d++) begin
            seed(32'hC0DE_0000 ^ (32'(d) << 7), 8'h01);
            wr(3, 8'(d));
            rd32(0, v); check("R7 sweep32", v, model(32'hC0DE_0000 ^ (32'(d) << 7), 32'h04C1_1DB7, 8'(d), 1));
        end

        // R1 reset again
        @(negedge clk); rst = 1; @(negedge clk); rst = 0;
        rd32(4, v); check("R1 poly after rst", v, 32'h0000_1021);
        wr(8, 8'h01); rd32(0, v); check("R1 data after rst", v, 32'hFFFF_FFFF);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule